// File: doc/BRIEF.md
# Double-Precision to 64-bit Integer Wrapping Converter

This block turns an IEEE 754 double-precision operand into a 64-bit two's-complement integer. It does not saturate: when the value is too large for 64 bits, the low 64 bits of the exact integer are returned and the overflow is reported by a flag. Software that wants an unsigned conversion can therefore use the same operation and keep the wrapped bits. The one negative value that fits exactly, -2^63, is accepted without flags.

The rounding direction comes from a 2-bit mode input. A separate chop control forces truncation toward zero whatever the mode says. A flush flag makes subnormal operands count as zero. Rounding works on a left-justified remainder word taken from the bits shifted out, and it is applied to the magnitude before any negation.

The block is a two-stage pipeline with a start/done handshake. It accepts a new operand every cycle, and each result appears two clock edges after its start.

Top module: `f64_to_i64_wrap`

## Requirements
- R1: An operand with an all-ones exponent (infinity or any NaN) gives result 0 with only the invalid flag set. Flags are read as {invalid_o, overflow_o, inexact_o}.
- R2: Positive or negative zero gives result 0 with no flags. A subnormal operand with flush_i high also gives 0 with no flags.
- R3: A subnormal operand with flush_i low is taken as a tiny nonzero value: the integer part is 0 with a sticky remainder, so inexact is raised and the mode decides the result (toward +inf gives 1 when positive, toward -inf gives -1 when negative, nearest gives 0).
- R4: For a normal operand, the left shift is the unbiased exponent minus 52. A shift from 0 to 10 gives the exact integer with no flags. A shift of 11 or more raises overflow and inexact and returns the low 64 bits of the shifted value. A shift of 64 or more returns 0.
- R5: The operand 0xC3E0000000000000 (-2^63) gives 0x8000000000000000 with no flags.
- R6: Mode 0 is round to nearest, ties to even. A remainder above one half adds 1, exactly one half adds the integer's LSB, and below one half adds nothing. Any nonzero remainder raises inexact.
- R7: Mode 1 is toward zero and adds nothing. Mode 2 (toward +inf) adds 1 to the magnitude of positive inexact values. Mode 3 (toward -inf) adds 1 to the magnitude of negative inexact values.
- R8: A negative operand returns the two's complement of the rounded magnitude, including wrapped overflow results.
- R9: When chop_i is high, the mode input is ignored and rounding is toward zero.
- R10: done_o rises exactly two clock edges after the edge that samples start_i, and one operand may start every cycle. When done_o is low, result and flags keep their last values.
- R11: While reset is active, and after it, done_o, result_o and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Operand valid this cycle |
| operand_i | input | 64 | Double-precision operand |
| rmode_i | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| chop_i | input | 1 | Force toward-zero rounding |
| flush_i | input | 1 | Treat subnormal operands as zero |
| done_o | output | 1 | Result and flags valid |
| result_o | output | 64 | Two's-complement integer, low 64 bits |
| invalid_o | output | 1 | Operand was infinity or NaN |
| overflow_o | output | 1 | Integer overflow, result wrapped |
| inexact_o | output | 1 | Result differs from the operand's value |

## Verification
Every result and flag is due on the second rising edge after the edge that samples start_i. The first stage holds the alignment and the second stage holds the rounding and negation. Each directed task drives its inputs on a falling edge, confirms that done_o is still low one falling edge later, and reads result and flags on the next falling edge, when done_o must be high. The streaming task sends three operands on back-to-back cycles and reads each result one cycle after the previous one. It then checks that the last result stays in place once done_o drops.

// File: rtl/dwi_pkg.sv
package dwi_pkg;
    localparam int INT_W  = 64;
    localparam int EXP_W  = 11;
    localparam int MAN_W  = 52;
    localparam int FP_W   = 1 + EXP_W + MAN_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int SH_ZERO = BIAS + MAN_W;        // exponent giving shift 0
    localparam int OVF_SH = INT_W - 1 - MAN_W;    // first overflowing shift
    localparam int SH_W   = EXP_W + 2;
    localparam int SHA_W  = $clog2(INT_W);

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rmode_e;

    typedef struct packed {
        logic              valid;
        logic              neg;
        logic [INT_W-1:0]  mag;
        logic [INT_W-1:0]  rem;
        rmode_e            mode;
        logic              inv;
        logic              iov;
    } mid_t;

    typedef struct packed {
        logic              done;
        logic [INT_W-1:0]  val;
        logic              inv;
        logic              iov;
        logic              ine;
    } out_t;
endpackage

// File: rtl/dwi_align.sv
module dwi_align
    import dwi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [FP_W-1:0] op_i,
    input  logic [1:0]      mode_i,
    input  logic            chop_i,
    input  logic            flush_i,
    output mid_t            mid_o
);
    localparam logic [FP_W-1:0] MIN_INT_FP =
        {1'b1, EXP_W'(BIAS + INT_W - 1), {MAN_W{1'b0}}};

    mid_t d, q;

    logic [EXP_W-1:0]   ex;
    logic [MAN_W-1:0]   fr;
    logic [INT_W-1:0]   sig;
    logic [SH_W-1:0]    shv;
    logic [SH_W-1:0]    rsh;
    logic [2*INT_W-1:0] wide;

    always_comb begin
        d    = q;
        ex   = op_i[FP_W-2:MAN_W];
        fr   = op_i[MAN_W-1:0];
        sig  = INT_W'({1'b1, fr});
        shv  = {2'b00, ex} - SH_W'(SH_ZERO);
        rsh  = SH_W'(0) - shv;
        wide = {sig, {INT_W{1'b0}}} >> rsh[SHA_W-1:0];
        d.valid = start_i;
        if (start_i) begin
            d.neg  = op_i[FP_W-1];
            d.mag  = '0;
            d.rem  = '0;
            d.inv  = 1'b0;
            d.iov  = 1'b0;
            d.mode = chop_i ? RM_ZERO : rmode_e'(mode_i);
            if (ex == '0) begin
                if (fr != '0 && !flush_i) begin
                    d.rem = INT_W'(1);
                end
            end else if (&ex) begin
                d.inv = 1'b1;
            end else if (!shv[SH_W-1]) begin
                if (shv < SH_W'(INT_W)) begin
                    d.mag = sig << shv[SHA_W-1:0];
                end
                if (shv >= SH_W'(OVF_SH) && op_i != MIN_INT_FP) begin
                    d.iov = 1'b1;
                end
            end else if (rsh < SH_W'(INT_W - 1)) begin
                d.mag = wide[2*INT_W-1:INT_W];
                d.rem = wide[INT_W-1:0];
            end else begin
                d.rem = INT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mid_o = q;

    // R2: a zero operand leaves no integer part, no remainder and no flag
    a_r2_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && op_i[FP_W-2:0] == '0 |=>
            q.mag == '0 && q.rem == '0 && !q.inv && !q.iov);

    // R1: specials carry nothing into rounding
    a_r1_special_empty: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid && q.inv |-> q.mag == '0 && q.rem == '0 && !q.iov);
endmodule

// File: rtl/dwi_round.sv
module dwi_round
    import dwi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  mid_t mid_i,
    output out_t out_o
);
    localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};

    out_t d, q;
    logic             inc;
    logic [INT_W-1:0] rnd;

    always_comb begin
        d   = q;
        inc = 1'b0;
        unique case (mid_i.mode)
            RM_NEAR: begin
                if (mid_i.rem == HALF)     inc = mid_i.mag[0];
                else if (mid_i.rem > HALF) inc = 1'b1;
            end
            RM_ZERO: inc = 1'b0;
            RM_UP:   inc = !mid_i.neg;
            RM_DOWN: inc = mid_i.neg;
            default: inc = 1'b0;
        endcase
        if (mid_i.rem == '0) inc = 1'b0;
        rnd = mid_i.mag + INT_W'(inc);
        d.done = mid_i.valid;
        if (mid_i.valid) begin
            d.val = mid_i.neg ? (INT_W'(0) - rnd) : rnd;
            d.inv = mid_i.inv;
            d.iov = mid_i.iov;
            d.ine = mid_i.iov | (mid_i.rem != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_o = q;

    // R7/R9: toward-zero on a positive value returns the aligned magnitude
    a_r7_chop_magnitude: assert property (@(posedge clk) disable iff (!rst_n)
        mid_i.valid && mid_i.mode == RM_ZERO && !mid_i.neg |=>
            q.val == $past(mid_i.mag));

    // R6: an exact aligned value never reports inexact
    a_r6_exact_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        mid_i.valid && mid_i.rem == '0 && !mid_i.iov |=> !q.ine);
endmodule

// File: rtl/f64_to_i64_wrap.sv
module f64_to_i64_wrap
    import dwi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [FP_W-1:0]  operand_i,
    input  logic [1:0]       rmode_i,
    input  logic             chop_i,
    input  logic             flush_i,
    output logic             done_o,
    output logic [INT_W-1:0] result_o,
    output logic             invalid_o,
    output logic             overflow_o,
    output logic             inexact_o
);
    mid_t mid;
    out_t res;

    dwi_align u_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .op_i    (operand_i),
        .mode_i  (rmode_i),
        .chop_i  (chop_i),
        .flush_i (flush_i),
        .mid_o   (mid)
    );

    dwi_round u_round (
        .clk   (clk),
        .rst_n (rst_n),
        .mid_i (mid),
        .out_o (res)
    );

    assign done_o     = res.done;
    assign result_o   = res.val;
    assign invalid_o  = res.inv;
    assign overflow_o = res.iov;
    assign inexact_o  = res.ine;

    // R10: done follows start by exactly two edges
    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> ##2 done_o);

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i, 2));

    // R10: outputs hold while idle
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o && $past(rst_n) |-> $stable(result_o) && $stable(inexact_o));

    // R5: the exempt most-negative value converts cleanly
    a_r5_exempt: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && operand_i == 64'hC3E0_0000_0000_0000 |-> ##2
            (result_o == 64'h8000_0000_0000_0000 && !overflow_o && !inexact_o));

    // R1/R4: invalid and overflow are never reported together
    a_r1_excl: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(invalid_o && overflow_o));
endmodule

// File: tb/f64_to_i64_wrap_test.sv
module f64_to_i64_wrap_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] operand_i = '0;
    logic [1:0]  rmode_i = '0;
    logic        chop_i = 1'b0;
    logic        flush_i = 1'b0;
    logic        done_o;
    logic [63:0] result_o;
    logic        invalid_o, overflow_o, inexact_o;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    f64_to_i64_wrap uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
        .rmode_i(rmode_i), .chop_i(chop_i), .flush_i(flush_i),
        .done_o(done_o), .result_o(result_o), .invalid_o(invalid_o),
        .overflow_o(overflow_o), .inexact_o(inexact_o)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // flags ordered {invalid, overflow, inexact}
    task automatic conv(input string req, input logic [63:0] op, input logic [1:0] md,
                        input logic ch, input logic fl,
                        input logic [63:0] exp_res, input logic [2:0] exp_flg);
        @(negedge clk);
        operand_i = op; rmode_i = md; chop_i = ch; flush_i = fl; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk({req, " R10 early done"}, 64'(done_o), 64'd0);
        @(negedge clk);
        chk({req, " R10 done"}, 64'(done_o), 64'd1);
        chk({req, " result"}, result_o, exp_res);
        chk({req, " flags"}, 64'({invalid_o, overflow_o, inexact_o}), 64'(exp_flg));
    endtask

    task automatic t_reset;
        chk("R11 reset done", 64'(done_o), 64'd0);
        chk("R11 reset result", result_o, 64'd0);
        chk("R11 reset flags", 64'({invalid_o, overflow_o, inexact_o}), 64'd0);
    endtask

    task automatic t_specials;
        conv("R1 +inf", 64'h7FF0_0000_0000_0000, 2'd0, 1'b0, 1'b0, 64'd0, 3'b100);
        conv("R1 -nan", 64'hFFF8_0000_0000_0000, 2'd2, 1'b0, 1'b0, 64'd0, 3'b100);
    endtask

    task automatic t_zero_sub;
        conv("R2 +0", 64'h0, 2'd2, 1'b0, 1'b0, 64'd0, 3'b000);
        conv("R2 -0", 64'h8000_0000_0000_0000, 2'd3, 1'b0, 1'b0, 64'd0, 3'b000);
        conv("R2 flushed subnormal", 64'h0000_0000_0000_0001, 2'd2, 1'b0, 1'b1, 64'd0, 3'b000);
        conv("R3 subnormal up", 64'h0000_0000_0000_0001, 2'd2, 1'b0, 1'b0, 64'd1, 3'b001);
        conv("R3 neg subnormal down", 64'h8000_0000_0000_0001, 2'd3, 1'b0, 1'b0,
             64'hFFFF_FFFF_FFFF_FFFF, 3'b001);
        conv("R3 subnormal nearest", 64'h0000_0000_0000_0001, 2'd0, 1'b0, 1'b0, 64'd0, 3'b001);
    endtask

    task automatic t_left;
        conv("R4 one", 64'h3FF0_0000_0000_0000, 2'd0, 1'b0, 1'b0, 64'd1, 3'b000);
        conv("R4 2^52", 64'h4330_0000_0000_0000, 2'd0, 1'b0, 1'b0, 64'h0010_0000_0000_0000, 3'b000);
        conv("R4 2^62", 64'h43D0_0000_0000_0000, 2'd0, 1'b0, 1'b0, 64'h4000_0000_0000_0000, 3'b000);
        conv("R4 2^63", 64'h43E0_0000_0000_0000, 2'd0, 1'b0, 1'b0, 64'h8000_0000_0000_0000, 3'b011);
        conv("R4 wrap", 64'h43F0_0000_0000_0001, 2'd0, 1'b0, 1'b0, 64'h0000_0000_0000_1000, 3'b011);
        conv("R4 shift 64", 64'h4730_0000_0000_0000, 2'd0, 1'b0, 1'b0, 64'd0, 3'b011);
    endtask

    task automatic t_exempt;
        conv("R5 -2^63", 64'hC3E0_0000_0000_0000, 2'd0, 1'b0, 1'b0, 64'h8000_0000_0000_0000, 3'b000);
    endtask

    task automatic t_nearest;
        conv("R6 2.5 tie even", 64'h4004_0000_0000_0000, 2'd0, 1'b0, 1'b0, 64'd2, 3'b001);
        conv("R6 3.5 tie odd", 64'h400C_0000_0000_0000, 2'd0, 1'b0, 1'b0, 64'd4, 3'b001);
        conv("R6 2.75 above", 64'h4006_0000_0000_0000, 2'd0, 1'b0, 1'b0, 64'd3, 3'b001);
        conv("R6 2.25 below", 64'h4002_0000_0000_0000, 2'd0, 1'b0, 1'b0, 64'd2, 3'b001);
        conv("R6 0.5 tie", 64'h3FE0_0000_0000_0000, 2'd0, 1'b0, 1'b0, 64'd0, 3'b001);
        conv("R6 0.75", 64'h3FE8_0000_0000_0000, 2'd0, 1'b0, 1'b0, 64'd1, 3'b001);
        conv("R6 just below half", 64'h3FDF_FFFF_FFFF_FFFF, 2'd0, 1'b0, 1'b0, 64'd0, 3'b001);
    endtask

    task automatic t_directed;
        conv("R7 2.75 zero", 64'h4006_0000_0000_0000, 2'd1, 1'b0, 1'b0, 64'd2, 3'b001);
        conv("R7 2.25 up", 64'h4002_0000_0000_0000, 2'd2, 1'b0, 1'b0, 64'd3, 3'b001);
        conv("R7 2.75 down", 64'h4006_0000_0000_0000, 2'd3, 1'b0, 1'b0, 64'd2, 3'b001);
        conv("R7 -2.5 up", 64'hC004_0000_0000_0000, 2'd2, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 3'b001);
        conv("R7 -2.5 down", 64'hC004_0000_0000_0000, 2'd3, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFD, 3'b001);
        conv("R7 0.5 up", 64'h3FE0_0000_0000_0000, 2'd2, 1'b0, 1'b0, 64'd1, 3'b001);
    endtask

    task automatic t_negative;
        conv("R8 -1.5 nearest", 64'hBFF8_0000_0000_0000, 2'd0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 3'b001);
        conv("R8 neg wrap", 64'hC3F0_0000_0000_0001, 2'd0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_F000, 3'b011);
        conv("R8 below -2^63", 64'hC3E0_0000_0000_0001, 2'd0, 1'b0, 1'b0, 64'h7FFF_FFFF_FFFF_F800, 3'b011);
    endtask

    task automatic t_chop;
        conv("R9 chop over nearest", 64'h4006_0000_0000_0000, 2'd0, 1'b1, 1'b0, 64'd2, 3'b001);
        conv("R9 chop over down", 64'hC004_0000_0000_0000, 2'd3, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFE, 3'b001);
        conv("R9 chop over up", 64'h4002_0000_0000_0000, 2'd2, 1'b1, 1'b0, 64'd2, 3'b001);
    endtask

    task automatic t_stream;
        @(negedge clk);
        rmode_i = 2'd0; chop_i = 1'b0; flush_i = 1'b0;
        operand_i = 64'h3FF0_0000_0000_0000; start_i = 1'b1;
        @(negedge clk);
        operand_i = 64'h4006_0000_0000_0000;
        @(negedge clk);
        chk("R10 stream first done", 64'(done_o), 64'd1);
        chk("R10 stream first", result_o, 64'd1);
        operand_i = 64'hC004_0000_0000_0000;
        @(negedge clk);
        start_i = 1'b0;
        chk("R10 stream second done", 64'(done_o), 64'd1);
        chk("R10 stream second", result_o, 64'd3);
        @(negedge clk);
        chk("R10 stream third done", 64'(done_o), 64'd1);
        chk("R10 stream third", result_o, 64'hFFFF_FFFF_FFFF_FFFE);
        @(negedge clk);
        chk("R10 idle done low", 64'(done_o), 64'd0);
        chk("R10 held result", result_o, 64'hFFFF_FFFF_FFFF_FFFE);
        chk("R10 held flags", 64'({invalid_o, overflow_o, inexact_o}), 64'b001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_specials();
        t_zero_sub();
        t_left();
        t_exempt();
        t_nearest();
        t_directed();
        t_negative();
        t_chop();
        t_stream();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule